// File: doc/BRIEF.md
# Pixel Column Derandomizing Readout with Token Ring

This block reads out one column of hit-recording pixels. Every pixel owns a small queue of time records, filled by its capture logic, so that bursts of hits are smoothed out before they reach the shared column bus. Each stored record carries a single-error-correcting, double-error-detecting Hamming code, so upsets in storage are repaired or flagged when the record is read.

An end-of-column controller owns a token. It starts the token at pixel 0 and sends it toward higher addresses. Pixels with empty queues pass it on within the same cycle. The first pixel that holds data keeps the token for one bus transfer, sends its column address with the decoded record, and then hands the token on. When the token reaches the end of the column without a transfer, the scan is finished and the controller restarts it on the next cycle.

An upset-injection input flips chosen bits of a stored codeword. It models radiation upsets so that the correction path can be exercised.

Top module: `col_token_readout`

## Requirements
- R1: While reset is held and right after it, `bus_valid`, `bus_sec`, `bus_ded` and `scan_done` are 0, every lost-hit counter is 0 and every pixel queue is empty.
- R2: Each pixel stores up to DEPTH (default 4) records and sends them in arrival order. A hit is accepted only if the queue held fewer than DEPTH records at the start of that cycle.
- R3: A hit refused under R2 is discarded, and the pixel's lost-hit counter (field p of `lost_cnt`, bits p*LOST_W upward) goes up by one. The counter stops at 2^LOST_W-1.
- R4: A record granted at a clock edge appears on `bus_valid`/`bus_addr`/`bus_data` for the following cycle. Within one scan, pixels are served in ascending address order, one record each.
- R5: Empty pixels pass the token in the same cycle. Two non-adjacent pixels holding data are therefore served on consecutive cycles.
- R6: A cycle in which the token reaches the end of the column without a transfer shows `scan_done`=1 and `bus_valid`=0. If pixel 0 holds data, it is served in the next cycle.
- R7: A single flipped bit anywhere in a stored 13-bit codeword (the default with DATA_W=8) is corrected on read, and `bus_sec`=1 is shown with the record.
- R8: Two flipped bits in a stored codeword give `bus_ded`=1 and `bus_sec`=0 with the record.
- R9: When `bus_valid` is 0, `bus_addr` and `bus_data` are driven to 0. Only a token holder puts data on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | NPIX | One hit strobe per pixel |
| hit_data | input | NPIX*DATA_W | Time record for each pixel, pixel p at bits p*DATA_W upward |
| upset_en | input | NPIX | Per-pixel upset injection enable |
| upset_mask | input | CW | Bits XORed into the codeword being written, or into the head entry when no write happens |
| bus_valid | output | 1 | A record is on the column bus |
| bus_addr | output | AW | Address of the pixel that drove the bus |
| bus_data | output | DATA_W | Decoded, corrected record |
| bus_sec | output | 1 | A single-bit error was corrected |
| bus_ded | output | 1 | A double-bit error was detected |
| scan_done | output | 1 | Token returned to the end of the column with no transfer |
| lost_cnt | output | NPIX*LOST_W | Saturating lost-hit counters, pixel p at bits p*LOST_W upward |

## Verification
The embedded properties assume that each pixel's hit strobe is sampled only at clock edges. They also assume that upset masks flip at most the bits the stimulus intends, and that reset is held for at least one edge before checking starts. The stimulus drives every input on the falling edge, so no strobe overlaps a sampling edge. It injects upsets only together with a write or into a non-empty queue, and it returns the column to idle, with the token back at pixel 0, before each directed scenario.

// File: rtl/col_token_readout.sv
module col_token_readout #(
  parameter int NPIX   = 8,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int LOST_W = 4,
  localparam int PW = (DATA_W <= 1) ? 2 : (DATA_W <= 4) ? 3 : (DATA_W <= 11) ? 4 : (DATA_W <= 26) ? 5 : 6,
  localparam int CW = DATA_W + PW + 1,
  localparam int AW = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPIX-1:0]          hit_valid,
  input  logic [NPIX*DATA_W-1:0]   hit_data,
  input  logic [NPIX-1:0]          upset_en,
  input  logic [CW-1:0]            upset_mask,
  output logic                     bus_valid,
  output logic [AW-1:0]            bus_addr,
  output logic [DATA_W-1:0]        bus_data,
  output logic                     bus_sec,
  output logic                     bus_ded,
  output logic                     scan_done,
  output logic [NPIX*LOST_W-1:0]   lost_cnt
);
  localparam int TW   = $clog2(NPIX + 1);
  localparam int PTRW = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [LOST_W-1:0] LMAX = '1;

  function automatic logic [CW-1:0] enc(input logic [DATA_W-1:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int j = 1; j < CW; j++)
      if ((j & (j - 1)) != 0) begin
        c[j] = d[k];
        k++;
      end
    for (int i = 0; i < PW; i++)
      for (int j = 1; j < CW; j++)
        if (((j >> i) & 1) == 1 && (j & (j - 1)) != 0) c[1 << i] = c[1 << i] ^ c[j];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [DATA_W+1:0] dec(input logic [CW-1:0] cin);
    logic [CW-1:0] c;
    logic [PW-1:0] syn;
    logic [DATA_W-1:0] d;
    logic s, e;
    int k;
    c = cin;
    syn = '0;
    for (int j = 1; j < CW; j++)
      if (c[j]) syn = syn ^ PW'(j);
    s = 1'b0;
    e = 1'b0;
    if (^c) begin
      if (int'(syn) < CW) begin
        s = 1'b1;
        if (syn != '0) c[syn] = ~c[syn];
      end else e = 1'b1;
    end else if (syn != '0) e = 1'b1;
    d = '0;
    k = 0;
    for (int j = 1; j < CW; j++)
      if ((j & (j - 1)) != 0) begin
        d[k] = c[j];
        k++;
      end
    return {e, s, d};
  endfunction

  logic [CW-1:0]     mem  [NPIX][DEPTH];
  logic [PTRW-1:0]   wp   [NPIX];
  logic [PTRW-1:0]   rp   [NPIX];
  logic [CNTW-1:0]   cnt  [NPIX];
  logic [LOST_W-1:0] lost [NPIX];
  logic [TW-1:0]     tok;

  logic              gnt;
  logic [AW-1:0]     gsel;
  logic [DATA_W+1:0] rd;

  always_comb begin
    gnt  = 1'b0;
    gsel = '0;
    for (int p = NPIX - 1; p >= 0; p--)
      if (TW'(p) >= tok && cnt[p] != '0) begin
        gnt  = 1'b1;
        gsel = AW'(p);
      end
  end

  assign rd = dec(mem[gsel][rp[gsel]]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPIX; p++) begin
        for (int q = 0; q < DEPTH; q++) mem[p][q] <= '0;
        wp[p]   <= '0;
        rp[p]   <= '0;
        cnt[p]  <= '0;
        lost[p] <= '0;
      end
      tok       <= '0;
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_data  <= '0;
      bus_sec   <= 1'b0;
      bus_ded   <= 1'b0;
      scan_done <= 1'b0;
    end else begin
      for (int p = 0; p < NPIX; p++) begin
        logic push, pop;
        push = hit_valid[p] && (int'(cnt[p]) < DEPTH);
        pop  = gnt && (gsel == AW'(p));
        if (push) begin
          mem[p][wp[p]] <= enc(hit_data[p*DATA_W +: DATA_W]) ^ (upset_en[p] ? upset_mask : '0);
          wp[p] <= (int'(wp[p]) == DEPTH - 1) ? '0 : wp[p] + 1'b1;
        end else if (upset_en[p] && cnt[p] != '0 && !pop)
          mem[p][rp[p]] <= mem[p][rp[p]] ^ upset_mask;
        if (pop) rp[p] <= (int'(rp[p]) == DEPTH - 1) ? '0 : rp[p] + 1'b1;
        cnt[p] <= cnt[p] + CNTW'(push) - CNTW'(pop);
        if (hit_valid[p] && !push && lost[p] != LMAX) lost[p] <= lost[p] + 1'b1;
      end
      tok       <= gnt ? TW'(gsel) + 1'b1 : '0;
      bus_valid <= gnt;
      bus_addr  <= gnt ? gsel : '0;
      bus_data  <= gnt ? rd[DATA_W-1:0] : '0;
      bus_sec   <= gnt & rd[DATA_W];
      bus_ded   <= gnt & rd[DATA_W+1];
      scan_done <= !gnt;
    end
  end

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    assign lost_cnt[p*LOST_W +: LOST_W] = lost[p];

    a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt[p]) <= DEPTH);

    a_r2_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr == AW'(p)) |-> $past(cnt[p]) != '0);

    a_r3_lost_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid[p] && int'(cnt[p]) == DEPTH && lost[p] != LMAX) |=> lost[p] == $past(lost[p]) + 1'b1);
  end

  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && $past(bus_valid)) |-> bus_addr > $past(bus_addr));

  a_r8_ded_excl: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ded |-> (bus_valid && !bus_sec));
endmodule

// File: tb/test_col_token_readout.sv
module test_col_token_readout;
  localparam int NPIX = 8, DATA_W = 8, LOST_W = 4, CW = 13, AW = 3;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NPIX-1:0]        hit_valid = '0;
  logic [NPIX*DATA_W-1:0] hit_data = '0;
  logic [NPIX-1:0]        upset_en = '0;
  logic [CW-1:0]          upset_mask = '0;
  logic                   bus_valid, bus_sec, bus_ded, scan_done;
  logic [AW-1:0]          bus_addr;
  logic [DATA_W-1:0]      bus_data;
  logic [NPIX*LOST_W-1:0] lost_cnt;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  col_token_readout i_col_token_readout (
    .clk, .rst_n, .hit_valid, .hit_data, .upset_en, .upset_mask,
    .bus_valid, .bus_addr, .bus_data, .bus_sec, .bus_ded, .scan_done, .lost_cnt);

  always #4 clk = ~clk;

  // {hit mask, data base (record = base + pixel), exp valid, exp addr, exp data, exp scan_done}
  localparam logic [28:0] VEC [17] = '{
    {8'h25, 8'hA0, 1'b0, 3'd0, 8'h00, 1'b1},
    {8'h04, 8'hB0, 1'b1, 3'd0, 8'hA0, 1'b0},
    {8'h00, 8'h00, 1'b1, 3'd2, 8'hA2, 1'b0},
    {8'h00, 8'h00, 1'b1, 3'd5, 8'hA5, 1'b0},
    {8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b1, 3'd2, 8'hB2, 1'b0},
    {8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1},
    {8'h82, 8'hC0, 1'b0, 3'd0, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b1, 3'd1, 8'hC1, 1'b0},
    {8'h00, 8'h00, 1'b1, 3'd7, 8'hC7, 1'b0},
    {8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1},
    {8'h08, 8'hD0, 1'b0, 3'd0, 8'h00, 1'b1},
    {8'h08, 8'hE0, 1'b1, 3'd3, 8'hD3, 1'b0},
    {8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b1, 3'd3, 8'hE3, 1'b0},
    {8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    hit_valid = '0;
    upset_en = '0;
    upset_mask = '0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic ecc_case(input logic [CW-1:0] mask, input bit exp_sec, input bit exp_ded, input string req);
    hit_valid = 8'h02;
    hit_data[1*DATA_W +: DATA_W] = 8'h5A;
    upset_en = 8'h02;
    upset_mask = mask;
    step();
    idle(1);
    check(bus_valid && bus_addr == 3'd1 && (exp_ded || bus_data == 8'h5A) &&
          bus_sec == exp_sec && bus_ded == exp_ded, req,
          {bus_valid, bus_addr, bus_data, bus_sec, bus_ded},
          {1'b1, 3'd1, 8'h5A, exp_sec, exp_ded});
    idle(3);
  endtask

  initial begin
    logic [7:0] obs [16];
    int nobs;
    logic [7:0] exp6 [8] = '{8'h60, 8'h61, 8'h62, 8'h63, 8'h64, 8'h65, 8'h66, 8'h68};

    @(negedge clk);
    step();
    // R1 reset state
    check(!bus_valid && !bus_sec && !bus_ded, "R1 outputs idle in reset", bus_valid, 0);
    check(!scan_done, "R1 scan_done low in reset", scan_done, 0);
    check(lost_cnt == '0, "R1 lost counters zero", lost_cnt, 0);
    rst_n = 1'b1;
    idle(2);
    check(!bus_valid && scan_done, "R1 empty column after reset", {bus_valid, scan_done}, 1);

    // R4 R5 R6 R9 vector table
    foreach (VEC[s]) begin
      logic [28:0] v;
      v = VEC[s];
      hit_valid = v[28:21];
      for (int p = 0; p < NPIX; p++) hit_data[p*DATA_W +: DATA_W] = v[20:13] + 8'(p);
      step();
      check(bus_valid == v[12] && bus_addr == v[11:9] && bus_data == v[8:1] && scan_done == v[0],
            $sformatf("R4 R5 R6 R9 step %0d", s),
            {bus_valid, bus_addr, bus_data, scan_done}, v[12:0]);
    end
    idle(3);

    // R2 R3 overflow on pixel 6
    nobs = 0;
    for (int i = 0; i < 22; i++) begin
      hit_valid = (i < 10) ? 8'h40 : 8'h00;
      hit_data[6*DATA_W +: DATA_W] = 8'h60 + 8'(i);
      step();
      if (i == 9) check(lost_cnt[6*LOST_W +: LOST_W] == 4'd2, "R3 two hits lost when full",
                        lost_cnt[6*LOST_W +: LOST_W], 2);
      if (bus_valid && bus_addr == 3'd6 && nobs < 16) begin
        obs[nobs] = bus_data;
        nobs++;
      end
    end
    check(nobs == 8, "R2 eight records accepted", nobs, 8);
    for (int i = 0; i < 8; i++)
      check(nobs > i && obs[i] == exp6[i], "R2 arrival order", obs[i], exp6[i]);

    // R3 saturation on pixel 4
    for (int i = 0; i < 40; i++) begin
      hit_valid = 8'h10;
      hit_data[4*DATA_W +: DATA_W] = 8'(i);
      step();
    end
    idle(20);
    check(lost_cnt[4*LOST_W +: LOST_W] == 4'hF, "R3 counter saturates", lost_cnt[4*LOST_W +: LOST_W], 15);
    check(lost_cnt[6*LOST_W +: LOST_W] == 4'd2, "R3 other counter unchanged", lost_cnt[6*LOST_W +: LOST_W], 2);

    // R7 R8 error correction
    ecc_case(13'h0008, 1'b1, 1'b0, "R7 data bit corrected");
    ecc_case(13'h0001, 1'b1, 1'b0, "R7 overall parity bit corrected");
    ecc_case(13'h1000, 1'b1, 1'b0, "R7 top bit corrected");
    ecc_case(13'h0030, 1'b0, 1'b1, "R8 double error flagged");
    ecc_case(13'h0000, 1'b0, 1'b0, "R7 clean record");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule